// File: doc/BRIEF.md
# Power-Up Pin Release Sequencer

This block decides when each group of a video decoder's output pins may leave high impedance after power is applied. An asynchronous active-low power-on reset forces every enable low. After reset release, the block holds all pins in high impedance for a programmable interval. It then runs an internal synchronous reset, during which the control-bus data pin and the line-locked clock pin are released. After that reset, it waits for a pulse reporting that a complete configuration transfer over the control bus has finished. Only that pulse releases the video data byte pins and the real-time status pins.

The power-on reset is applied asynchronously to every register. Its release is synchronised through a short flop chain. All enables come straight from flops, one flop per pin, so decode glitches never reach the pad drivers. A configuration pulse seen during the hold or synchronous-reset stages is remembered and used as soon as the waiting stage begins. Once running, the block stays running until the next power-on reset.

Top module: `pin_release_seq`

## Requirements
- R1: While `por_n` is low, `bus_oe`, `lclk_oe`, every bit of `vid_oe` and `sts_oe` are 0 and `core_srst` is 1, without any clock edge being needed.
- R2: Counting rising clock edges after `por_n` goes high as 1, 2, ..., the internal reset is released after edge SYNC_STAGES. All enables stay 0 and `core_srst` stays 1 through edge SYNC_STAGES+HIZ_CYCLES-1.
- R3: From edge SYNC_STAGES+HIZ_CYCLES, `bus_oe` and `lclk_oe` are 1 and `core_srst` stays 1 for SRST_CYCLES edges, while `vid_oe` and `sts_oe` stay 0.
- R4: At edge W = SYNC_STAGES+HIZ_CYCLES+SRST_CYCLES, `core_srst` goes to 0 and `bus_oe`/`lclk_oe` stay 1. `vid_oe` and `sts_oe` stay 0 until a configuration pulse is accepted.
- R5: A `cfg_done` high sampled at an edge while waiting for configuration sets all `vid_oe` and `sts_oe` bits to 1 at that same edge.
- R6: A `cfg_done` high sampled at an edge after SYNC_STAGES and no later than W is remembered, and video and status enables turn on at edge W+1.
- R7: A `cfg_done` high sampled at an edge no later than SYNC_STAGES (internal reset still active) is ignored: the block keeps waiting with `vid_oe`/`sts_oe` at 0.
- R8: Once the video enables are on, they and the bus enables stay on, and further `cfg_done` pulses change nothing, until `por_n` is lowered.
- R9: Lowering `por_n` at any stage returns all outputs to the R1 state, and the whole sequence restarts from R2 when it is raised.
- R10: `vid_oe` and `sts_oe` are never non-zero while `bus_oe` or `lclk_oe` is 0, and all of their bits always switch together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_done | input | 1 | One-cycle pulse: a full configuration transfer has completed |
| bus_oe | output | 1 | Output enable of the control-bus data pin |
| lclk_oe | output | 1 | Output enable of the line-locked clock pin |
| vid_oe | output | VID_W | Output enables of the video data byte pins |
| sts_oe | output | STS_W | Output enables of the real-time status pins |
| core_srst | output | 1 | Synchronous reset to the rest of the decoder, active high |

## Verification
The bench builds the block with SYNC_STAGES=2, HIZ_CYCLES=5 and SRST_CYCLES=3, an 8-bit video group and a 3-bit status group. These values make the full sequence ten edges long, so every stage boundary can be reached in a few cycles. With that length, the bench places a configuration pulse at every edge from before internal reset release to after the waiting stage begins. It also lowers the power-on reset after every edge of the sequence and compares each output at every edge with a value derived from the stage lengths.

// File: rtl/pin_seq_pkg.sv
package pin_seq_pkg;

   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,
      ST_SRST = 2'd1,
      ST_WAIT = 2'd2,
      ST_RUN  = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic bus;
      logic lclk;
      logic vid;
      logic srst;
   } pin_plan_t;

   function automatic pin_plan_t plan_of(seq_state_t st);
      pin_plan_t p;
      unique case (st)
         ST_HOLD: p = '{bus: 1'b0, lclk: 1'b0, vid: 1'b0, srst: 1'b1};
         ST_SRST: p = '{bus: 1'b1, lclk: 1'b1, vid: 1'b0, srst: 1'b1};
         ST_WAIT: p = '{bus: 1'b1, lclk: 1'b1, vid: 1'b0, srst: 1'b0};
         default: p = '{bus: 1'b1, lclk: 1'b1, vid: 1'b1, srst: 1'b0};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/prs_rst_sync.sv
module prs_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q[0] <= 1'b0;
      else         chain_q[0] <= 1'b1;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) chain_q[i] <= 1'b0;
         else         chain_q[i] <= chain_q[i-1];
      end
   end

   assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/prs_stage_timer.sv
module prs_stage_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] cnt_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/prs_cfg_latch.sv
module prs_cfg_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   input  logic consume_i,
   output logic pend_o
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q <= 1'b0;
      else if (consume_i) pend_q <= 1'b0;
      else if (pulse_i)   pend_q <= 1'b1;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/prs_oe_bank.sv
module prs_oe_bank #(
   parameter int W       = 1,
   parameter bit RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   output logic [W-1:0] oe_o
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= RST_VAL;
         else        pin_q <= en_i;
      end
      assign oe_o[i] = pin_q;
   end
endmodule

// File: rtl/pin_release_seq.sv
module pin_release_seq
   import pin_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HIZ_CYCLES  = 2500000,
   parameter int SRST_CYCLES = 64,
   parameter int VID_W       = 8,
   parameter int STS_W       = 3
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             cfg_done,
   output logic             bus_oe,
   output logic             lclk_oe,
   output logic [VID_W-1:0] vid_oe,
   output logic [STS_W-1:0] sts_oe,
   output logic             core_srst
);
   localparam int MAXLEN = (HIZ_CYCLES > SRST_CYCLES) ? HIZ_CYCLES : SRST_CYCLES;
   localparam int CW     = $clog2(MAXLEN + 1);
   localparam logic [CW-1:0] HIZ_LAST  = CW'(HIZ_CYCLES - 1);
   localparam logic [CW-1:0] SRST_LAST = CW'(SRST_CYCLES - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (HIZ_CYCLES < 1) begin : g_bad_hiz
      $error("HIZ_CYCLES must be at least 1");
   end
   if (SRST_CYCLES < 1) begin : g_bad_srst
      $error("SRST_CYCLES must be at least 1");
   end
   if (VID_W < 1 || STS_W < 1) begin : g_bad_width
      $error("pin group widths must be at least 1");
   end

   logic          rst_i_n;
   logic [CW-1:0] cnt;
   logic          tmr_clr;
   logic          pend;
   seq_state_t    state_q, state_d;
   pin_plan_t     plan_d;
   logic [0:0]    bus_v, lclk_v, srst_v;

   prs_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .arst_n  (por_n),
      .rst_n_o (rst_i_n)
   );

   prs_stage_timer #(.CW(CW)) i_timer (
      .clk   (clk),
      .rst_n (rst_i_n),
      .clr   (tmr_clr),
      .cnt_o (cnt)
   );

   prs_cfg_latch i_cfg (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .pulse_i   (cfg_done),
      .consume_i (state_q == ST_RUN),
      .pend_o    (pend)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_HOLD: if (cnt == HIZ_LAST)  state_d = ST_SRST;
         ST_SRST: if (cnt == SRST_LAST) state_d = ST_WAIT;
         ST_WAIT: if (cfg_done || pend) state_d = ST_RUN;
         default: state_d = ST_RUN;
      endcase
   end

   assign tmr_clr = (state_d != state_q) || (state_q == ST_WAIT) || (state_q == ST_RUN);
   assign plan_d  = plan_of(state_d);

   always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) state_q <= ST_HOLD;
      else          state_q <= state_d;
   end

   prs_oe_bank #(.W(1), .RST_VAL(1'b0)) i_bus (
      .clk (clk), .rst_n (rst_i_n), .en_i (plan_d.bus), .oe_o (bus_v)
   );
   prs_oe_bank #(.W(1), .RST_VAL(1'b0)) i_lclk (
      .clk (clk), .rst_n (rst_i_n), .en_i (plan_d.lclk), .oe_o (lclk_v)
   );
   prs_oe_bank #(.W(VID_W), .RST_VAL(1'b0)) i_vid (
      .clk (clk), .rst_n (rst_i_n), .en_i (plan_d.vid), .oe_o (vid_oe)
   );
   prs_oe_bank #(.W(STS_W), .RST_VAL(1'b0)) i_sts (
      .clk (clk), .rst_n (rst_i_n), .en_i (plan_d.vid), .oe_o (sts_oe)
   );
   prs_oe_bank #(.W(1), .RST_VAL(1'b1)) i_srst (
      .clk (clk), .rst_n (rst_i_n), .en_i (plan_d.srst), .oe_o (srst_v)
   );

   assign bus_oe    = bus_v[0];
   assign lclk_oe   = lclk_v[0];
   assign core_srst = srst_v[0];
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
   parameter int VID_W = 8,
   parameter int STS_W = 3
) (
   input logic             clk,
   input logic             por_n,
   input logic             cfg_done,
   input logic             bus_oe,
   input logic             lclk_oe,
   input logic [VID_W-1:0] vid_oe,
   input logic [STS_W-1:0] sts_oe,
   input logic             core_srst
);
   logic cfg_seen_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        cfg_seen_q <= 1'b0;
      else if (cfg_done) cfg_seen_q <= 1'b1;
   end

   // R1
   p_por_all_off_r1: assert property (@(posedge clk)
      !por_n |-> (!bus_oe && !lclk_oe && vid_oe == '0 && sts_oe == '0 && core_srst));

   // R3
   p_bus_sticky_r3: assert property (@(posedge clk) disable iff (!por_n)
      (bus_oe && lclk_oe) |=> (bus_oe && lclk_oe));

   // R4
   p_srst_release_r4: assert property (@(posedge clk) disable iff (!por_n)
      $fell(core_srst) |-> (bus_oe && lclk_oe && vid_oe == '0));

   // R4
   p_vid_after_srst_r4: assert property (@(posedge clk) disable iff (!por_n)
      (vid_oe != '0) |-> !core_srst);

   // R5
   p_vid_needs_cfg_r5: assert property (@(posedge clk) disable iff (!por_n)
      $rose(vid_oe[0]) |-> (cfg_seen_q || cfg_done));

   // R8
   p_run_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
      vid_oe[0] |=> (vid_oe[0] && !core_srst));

   // R10
   p_grp_order_r10: assert property (@(posedge clk) disable iff (!por_n)
      (vid_oe != '0 || sts_oe != '0) |-> (bus_oe && lclk_oe));

   // R10
   p_grp_uniform_r10: assert property (@(posedge clk) disable iff (!por_n)
      ((vid_oe == '0 || vid_oe == '1) && (sts_oe == '0 || sts_oe == '1)
       && ((vid_oe == '0) == (sts_oe == '0))));
endmodule

bind pin_release_seq prs_checker #(.VID_W(VID_W), .STS_W(STS_W)) i_prs_checker (
   .clk       (clk),
   .por_n     (por_n),
   .cfg_done  (cfg_done),
   .bus_oe    (bus_oe),
   .lclk_oe   (lclk_oe),
   .vid_oe    (vid_oe),
   .sts_oe    (sts_oe),
   .core_srst (core_srst)
);

// File: tb/test_pin_release_seq.sv
module test_pin_release_seq;
   localparam int S  = 2;
   localparam int H  = 5;
   localparam int R  = 3;
   localparam int VW = 8;
   localparam int SW = 3;
   localparam int W  = S + H + R;
   localparam int VL = 3 + VW + SW;

   logic          clk = 1'b0;
   logic          por_n = 1'b1;
   logic          cfg_done = 1'b0;
   logic          bus_oe, lclk_oe, core_srst;
   logic [VW-1:0] vid_oe;
   logic [SW-1:0] sts_oe;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pin_release_seq #(
      .SYNC_STAGES(S), .HIZ_CYCLES(H), .SRST_CYCLES(R), .VID_W(VW), .STS_W(SW)
   ) i_pin_release_seq (
      .clk(clk), .por_n(por_n), .cfg_done(cfg_done), .bus_oe(bus_oe),
      .lclk_oe(lclk_oe), .vid_oe(vid_oe), .sts_oe(sts_oe), .core_srst(core_srst)
   );

   function automatic logic [VL-1:0] pack(logic b, logic l, logic v, logic s);
      return {b, l, {VW{v}}, {SW{v}}, s};
   endfunction

   // Expected outputs after edge k; c = edge carrying the first pulse (0 = none)
   function automatic logic [VL-1:0] expect_at(int k, int c);
      int run_at;
      if (k < S + H) return pack(1'b0, 1'b0, 1'b0, 1'b1);
      if (k < W)     return pack(1'b1, 1'b1, 1'b0, 1'b1);
      if (c <= S) return pack(1'b1, 1'b1, 1'b0, 1'b0);
      run_at = (c > W + 1) ? c : W + 1;
      return pack(1'b1, 1'b1, (k >= run_at), 1'b0);
   endfunction

   function automatic string tag_at(int k, int c);
      if (k < S + H) return "R2";
      if (k < W)     return "R3";
      if (c == 0)    return "R4";
      if (c <= S)    return "R7";
      if (k > c + 1 && k > W + 1) return "R8";
      if (c <= W)    return "R6";
      return "R5";
   endfunction

   function automatic logic [VL-1:0] actual();
      return {bus_oe, lclk_oe, vid_oe, sts_oe, core_srst};
   endfunction

   task automatic check_vec(string tag, logic [VL-1:0] act, logic [VL-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: outputs %b, expected %b", tag, act, exp);
      end
   endtask

   task automatic check_order();
      // R10: video/status group only with bus pins released
      checks++;
      if ((vid_oe != '0 || sts_oe != '0) && !(bus_oe && lclk_oe)) begin
         errors++;
         $display("FAIL R10: bus %b lclk %b vid %b sts %b, expected bus enables on",
                  bus_oe, lclk_oe, vid_oe, sts_oe);
      end
   endtask

   // Lowers por_n at the current time and holds it for two clocks (R1, R9)
   task automatic por_pulse(string tag);
      cfg_done = 1'b0;
      por_n = 1'b0;
      #1;
      check_vec(tag, actual(), pack(1'b0, 1'b0, 1'b0, 1'b1));
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         check_vec("R1", actual(), pack(1'b0, 1'b0, 1'b0, 1'b1));
      end
   endtask

   // Called at a negedge; raises por_n and checks n edges
   task automatic run_seq(int c, int n);
      por_n = 1'b1;
      for (int k = 1; k <= n; k++) begin
         cfg_done = (k == c) || (c > S && k == c + 4);
         @(posedge clk);
         @(negedge clk);
         check_vec(tag_at(k, c), actual(), expect_at(k, c));
         check_order();
      end
      cfg_done = 1'b0;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      por_pulse("R1");
      // pulse position sweep: R5, R6, R7, R8
      for (int c = 0; c <= W + 4; c++) begin
         run_seq(c, W + 9);
         por_pulse("R9");
      end
      // reset at every stage, then full restart: R9
      for (int j = 1; j <= W + 3; j++) begin
         run_seq(W + 1, j);
         por_pulse("R9");
         run_seq(W + 2, W + 6);
         por_pulse("R9");
      end
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule